// File: doc/BRIEF.md
# Buffered Queue Pointer Control Register

This block holds the control word that steers the queue sequencer of a queued SPI master. The word carries a start pointer, an end pointer, two wraparound controls and an enable for the finished interrupt. The block also owns the queue pointer that the sequencer follows. It moves that pointer one entry at a time as each serial transfer completes. When the entry at the end pointer finishes, the block raises a sticky finished flag.

A bus write does not reach the active word at once. It is merged into a shadow buffer, byte lane by byte lane. The buffer is committed at the next transfer boundary, or on the following clock when the shift engine is idle. Reads always show the active word. A committed write that included the low byte counts as a rewrite of the start pointer. It relaunches the sequencer at that entry.

Top module: `qspi_qctl`

## Requirements
- R1: After reset the read word, the queue pointer, the run indication, the finished flag and the interrupt output are all zero.
- R2: The read word places interrupt enable at bit 15, wrap enable at bit 14, wrap-to select at bit 13, end pointer at bits 11:8 and start pointer at bits 3:0. Every other bit reads as zero.
- R3: While `xfer_active` is high, a write leaves the read word and the queue pointer unchanged. It is committed on the clock edge where `entry_done` is high and `bus_wr` is low, and it shows after that edge.
- R4: With `xfer_active` low, a write is committed on the clock edge that follows the write edge.
- R5: A committed write whose byte enable bit 0 was set loads the queue pointer with the new start pointer and sets the run indication. This overrides any advance on the same edge.
- R6: A committed write that touched only the high byte, or no byte, leaves the queue pointer and the run indication unchanged.
- R7: While running, each `entry_done` pulse that is not at the end pointer adds one to the queue pointer. `entry_done` has no effect while halted.
- R8: An `entry_done` at the end pointer sets the finished flag. With wrap disabled, it also clears the run indication and leaves the pointer in place.
- R9: With wrap enabled, an `entry_done` at the end pointer keeps the sequencer running. The pointer goes to the start pointer when wrap-to is 1, and to entry 0 when wrap-to is 0.
- R10: The finished flag stays set until a `fin_clr` pulse. If a new finish and a clear arrive on the same edge, the flag ends up set.
- R11: `irq` is high exactly when the finished flag is set and the active interrupt enable is 1.
- R12: Several writes made before a commit merge per byte lane into the buffer, and the latest data wins in each lane. A start-pointer rewrite in any of them still causes a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_be | input | 2 | Byte enables (bit 1 high byte, bit 0 low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Active control word |
| fin_clr | input | 1 | Clears the finished flag |
| xfer_active | input | 1 | A serial transfer is in progress |
| entry_done | input | 1 | Pulse: the current queue entry finished |
| qptr | output | 4 | Current queue pointer |
| q_run | output | 1 | Sequencer is running |
| fin_flag | output | 1 | Finished flag |
| irq | output | 1 | Finished interrupt |

## Verification
One corner case is a write that lands in the middle of a transfer. A design that skipped the buffer would change the read word early. Another is a restart commit that coincides with an entry completion. If the plain advance wins there, the pointer shows the old value plus one instead of the new start entry. The bench also checks the wrap paths, where mixing up the wrap-to choice sends the pointer to the wrong entry. It checks a high-byte-only write, which a careless design would treat as a restart. It checks a finish and a clear arriving together, where a clear-first design drops the flag. Finally, it checks split-lane writes committed together, where a design that overwrote the whole buffer would lose the first lane.

// File: rtl/qspi_qctl.sv
module qspi_qctl #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_be,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             fin_clr,
  input  logic             xfer_active,
  input  logic             entry_done,
  output logic [PTR_W-1:0] qptr,
  output logic             q_run,
  output logic             fin_flag,
  output logic             irq
);
  localparam logic [7:0]  PTR_MASK  = 8'((1 << PTR_W) - 1);
  localparam logic [15:0] IMPL_MASK = {8'hE0 | PTR_MASK, PTR_MASK};

  logic [15:0] act_word, pend_word, base_word, merged;
  logic        pend_valid, pend_rs;
  logic        apply, restart;
  logic [PTR_W-1:0] end_p, new_p;

  assign base_word = pend_valid ? pend_word : act_word;
  assign merged = {bus_be[1] ? bus_wdata[15:8] : base_word[15:8],
                   bus_be[0] ? bus_wdata[7:0]  : base_word[7:0]} & IMPL_MASK;

  assign apply   = pend_valid & ~bus_wr & (~xfer_active | entry_done);
  assign restart = apply & pend_rs;

  assign end_p     = act_word[8 +: PTR_W];
  assign new_p     = act_word[0 +: PTR_W];
  assign bus_rdata = act_word;
  assign irq       = fin_flag & act_word[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_word  <= '0;
      pend_valid <= 1'b0;
      pend_rs    <= 1'b0;
    end else if (bus_wr) begin
      pend_word  <= merged;
      pend_valid <= 1'b1;
      pend_rs    <= (pend_valid & pend_rs) | bus_be[0];
    end else if (apply) begin
      pend_valid <= 1'b0;
      pend_rs    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act_word <= '0;
    else if (apply) act_word <= pend_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qptr  <= '0;
      q_run <= 1'b0;
    end else if (restart) begin
      qptr  <= pend_word[0 +: PTR_W];
      q_run <= 1'b1;
    end else if (q_run && entry_done) begin
      if (qptr == end_p) begin
        if (act_word[14]) qptr <= act_word[13] ? new_p : '0;
        else              q_run <= 1'b0;
      end else begin
        qptr <= qptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     fin_flag <= 1'b0;
    else if (q_run && entry_done && qptr == end_p)  fin_flag <= 1'b1;
    else if (fin_clr)                               fin_flag <= 1'b0;
  end

  // R3: the active word holds while a transfer runs with no boundary
  a_r3_hold_mid_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active && !entry_done |=> $stable(bus_rdata));

  // R4: a pending write commits right away when idle
  a_r4_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && !bus_wr && !xfer_active |=> !pend_valid);

  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    q_run && entry_done && qptr != end_p && !restart |=> qptr == $past(qptr) + 1'b1);

  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    q_run && entry_done && qptr == end_p && !act_word[14] && !restart |=> !q_run);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fin_flag && !fin_clr |=> fin_flag);

  a_r5_restart_runs: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> q_run);
endmodule

// File: tb/tb_qspi_qctl.sv
`timescale 1ns/1ps
module tb_qspi_qctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        fin_clr = 1'b0;
  logic        xfer_active = 1'b0;
  logic        entry_done = 1'b0;
  logic [3:0]  qptr;
  logic        q_run, fin_flag, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  qspi_qctl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fin_clr(fin_clr),
    .xfer_active(xfer_active), .entry_done(entry_done), .qptr(qptr),
    .q_run(q_run), .fin_flag(fin_flag), .irq(irq)
  );

  // {be[1:0], wdata[15:0], exp_rd[15:0], exp_qptr[3:0], exp_run}
  localparam logic [38:0] VEC [6] = '{
    {2'b11, 16'hFFFF, 16'hEF0F, 4'hF, 1'b1},
    {2'b10, 16'h0300, 16'h030F, 4'hF, 1'b1},
    {2'b01, 16'h00A5, 16'h0305, 4'h5, 1'b1},
    {2'b11, 16'h8A42, 16'h8A02, 4'h2, 1'b1},
    {2'b11, 16'h6000, 16'h6000, 4'h0, 1'b1},
    {2'b00, 16'hFFFF, 16'h6000, 4'h0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic done(input logic clr);
    @(negedge clk);
    entry_done = 1'b1; fin_clr = clr;
    @(negedge clk);
    entry_done = 1'b0; fin_clr = 1'b0;
  endtask

  task automatic clr_fin();
    @(negedge clk);
    fin_clr = 1'b1;
    @(negedge clk);
    fin_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", bus_rdata, 0); chk("R1 qptr", qptr, 0);
    chk("R1 run", q_run, 0); chk("R1 fin", fin_flag, 0); chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][38:37], VEC[i][36:21]);
      @(negedge clk);
      chk("R2/R4 rdata", bus_rdata, VEC[i][20:5]);
      chk("R5/R6 qptr", qptr, VEC[i][4:1]);
      chk("R5/R6 run", q_run, VEC[i][0]);
    end

    // R7 R8: no wrap, end=3 start=2
    wr(2'b11, 16'h0302); @(negedge clk);
    chk("R5 qptr", qptr, 2);
    done(1'b0); chk("R7 advance", qptr, 3);
    done(1'b0);
    chk("R8 fin", fin_flag, 1); chk("R8 halt", q_run, 0); chk("R8 qptr", qptr, 3);
    chk("R11 irq off", irq, 0);
    done(1'b0); chk("R7 ignored when halted", qptr, 3);

    // R11: enable interrupt, high byte only
    wr(2'b10, 16'h8000); @(negedge clk);
    chk("R11 irq on", irq, 1); chk("R6 run kept", q_run, 0);
    clr_fin();
    chk("R10 cleared", fin_flag, 0); chk("R11 irq after clear", irq, 0);

    // R9: wrap to start
    wr(2'b11, 16'h6201); @(negedge clk);
    chk("R5 qptr", qptr, 1);
    done(1'b0); chk("R7 advance", qptr, 2);
    done(1'b0);
    chk("R9 wrap-to start", qptr, 1); chk("R9 running", q_run, 1);
    chk("R8 fin on wrap", fin_flag, 1);
    wr(2'b10, 16'h4200); @(negedge clk);
    chk("R6 no restart", qptr, 1);
    done(1'b0); chk("R7 advance", qptr, 2);
    done(1'b0); chk("R9 wrap-to zero", qptr, 0); chk("R9 running", q_run, 1);

    // R10: set wins over clear
    clr_fin(); chk("R10 cleared", fin_flag, 0);
    done(1'b0); done(1'b0);
    chk("R7 qptr", qptr, 2);
    done(1'b1); chk("R10 set wins", fin_flag, 1); chk("R9 qptr", qptr, 0);
    clr_fin(); chk("R10 clear", fin_flag, 0);

    // R3: write during a transfer
    xfer_active = 1'b1;
    wr(2'b11, 16'h0107);
    repeat (3) @(negedge clk);
    chk("R3 rdata held", bus_rdata, 16'h4201); chk("R3 qptr held", qptr, 0);
    done(1'b0);
    chk("R3 rdata at boundary", bus_rdata, 16'h0107);
    chk("R5 restart overrides advance", qptr, 7);

    // R12: split-lane writes merge
    wr(2'b10, 16'h8500);
    wr(2'b01, 16'h0003);
    @(negedge clk);
    chk("R12 pending hidden", bus_rdata, 16'h0107);
    done(1'b0);
    chk("R12 merged", bus_rdata, 16'h8503); chk("R12 restart", qptr, 3);
    xfer_active = 1'b0;

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rdata", bus_rdata, 0); chk("R1 qptr", qptr, 0); chk("R1 run", q_run, 0);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule